// File: doc/BRIEF.md
# Memory-Mapped 64-Source Interrupt Controller

This block collects up to 64 interrupt inputs, gates each one with its own enable bit and raises a single registered request line toward the processor. Every input is assigned at build time to one of two behaviours. A level input counts as active for exactly as long as it is driven high. A pulse input sets a sticky flag that keeps the source active after the input falls, until software clears the flag. The processor reaches all state through a zero-wait-state APB slave port using full 32-bit words.

Status is read in two 32-bit pending words, one for sources 0 to 31 and one for sources 32 to 63. A master switch in the control word must be on before any request reaches the processor. A table of 64 byte-wide slots, four per word, holds one source index per channel slot. Initialisation software fills each word with four consecutive indices, the lowest index in the top byte lane. The hardware keeps each index and returns it on read.

Top module: `irqhub_apb`

## Requirements
- R1: After reset every readable register returns 0, irq_req is 0, pready is 1 and pslverr is 0.
- R2: The enable words at 0x10 (sources 0-31) and 0x28 (sources 32-63) are read/write, with bit i belonging to source i or source 32+i.
- R3: The pending words at 0x14 (low) and 0x2C (high) read as enable AND active for each source. Writes to them change no state.
- R4: A source whose mode bit in PULSE_SRC is 0 is active while its input is high. Its flag bit always reads 0.
- R5: A source whose mode bit is 1 sets its flag bit on any cycle its input is high. The bit stays set with the input low. The flag words sit at 0x08 (low) and 0x20 (high).
- R6: A write to a flag word clears every flag bit written as 0 and leaves every bit written as 1 unchanged. A write never sets a flag.
- R7: When a pulse source is high in the same cycle that a write clears its flag, the flag stays set.
- R8: Only bit 31 of the control word at 0x00 is stored, and the other bits read 0. While bit 31 is 0, irq_req stays 0.
- R9: irq_req is a register that holds, one clock later, the OR of all pending bits ANDed with control bit 31.
- R10: The routing table spans 16 words from 0x40 to 0x7C. In every byte lane the low IDX_W bits are stored, and the upper bits of the lane read 0.
- R11: Reads of any other word offset return 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Asynchronous reset, active low |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | ADDR_W | Byte address; bits 1:0 are ignored |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| irq_src | input | NSRC | Interrupt inputs, synchronous to pclk |
| irq_req | output | 1 | Registered request to the processor |

## Verification
Two actions can land on a pulse flag at the same clock edge: hardware setting it from the input, and a software write clearing it. The bench first sets two pulse flags. It then issues a write of zero to the flag word and raises only one of those two inputs during the access phase. It expects the raised bit to survive and the other to be cleared. Random traffic also mixes pulses, flag clears and enable writes, and every pending read and every request sample is compared against a bench model.

// File: rtl/irqhub_pkg.sv
package irqhub_pkg;
   localparam int unsigned WORD_W      = 32;
   localparam int unsigned LANE_W      = 8;
   localparam int unsigned CTRL_ON_BIT = 31;
   // word offsets (byte address / 4); flag word lies two words below its enable word
   localparam int unsigned OFS_CTRL    = 0;
   localparam int unsigned OFS_EN_LO   = 4;
   localparam int unsigned OFS_PEND_LO = 5;
   localparam int unsigned OFS_EN_HI   = 10;
   localparam int unsigned OFS_PEND_HI = 11;
   localparam int unsigned FLAG_GAP    = 2;
   localparam int unsigned OFS_ROUTE   = 16;
   localparam int unsigned ROUTE_WORDS = 16;
endpackage

// File: rtl/irqhub_word.sv
module irqhub_word #(
   parameter int unsigned W     = 32,
   parameter logic [W-1:0] PULSE = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] src,
   input  logic         en_we,
   input  logic         flag_we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] en,
   output logic [W-1:0] flag,
   output logic [W-1:0] pend
);
   logic [W-1:0] active;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     en <= '0;
      else if (en_we) en <= wdata;
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (PULSE[i]) begin : g_pulse
         logic f_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) f_q <= 1'b0;
            else        f_q <= (flag_we ? (f_q & wdata[i]) : f_q) | src[i];
         end
         assign flag[i]   = f_q;
         assign active[i] = f_q;
      end else begin : g_level
         assign flag[i]   = 1'b0;
         assign active[i] = src[i];
      end
   end

   assign pend = en & active;

   // R5: without a flag write, no set flag bit drops
   p_flag_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(flag_we)) |-> ((flag & $past(flag)) == $past(flag)));

   // R7: a high pulse input always leaves its flag set, even against a clear
   p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> ((flag & $past(src & PULSE)) == $past(src & PULSE)));

   // R6: a flag write never sets a bit that was clear and not pulsed
   p_no_sw_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> ((flag & ~$past(flag) & ~$past(src)) == '0));
endmodule

// File: rtl/irqhub_route.sv
module irqhub_route #(
   parameter int unsigned SLOTS = 64,
   parameter int unsigned IDX_W = 6,
   localparam int unsigned WORDS = SLOTS / 4,
   localparam int unsigned AW    = $clog2(WORDS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] wsel,
   input  logic [31:0]   wdata,
   input  logic [AW-1:0] rsel,
   output logic [31:0]   rdata
);
   logic [IDX_W-1:0] tbl [SLOTS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SLOTS; s++) tbl[s] <= '0;
      end else if (we) begin
         for (int ln = 0; ln < 4; ln++)
            tbl[{wsel, 2'(ln)}] <= wdata[ln*8 +: IDX_W];
      end
   end

   always_comb begin
      rdata = '0;
      for (int ln = 0; ln < 4; ln++)
         rdata[ln*8 +: 8] = 8'(tbl[{rsel, 2'(ln)}]);
   end
endmodule

// File: rtl/irqhub_apb.sv
module irqhub_apb
   import irqhub_pkg::*;
#(
   parameter int unsigned NSRC      = 64,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned IDX_W     = 6,
   parameter logic [63:0] PULSE_SRC = 64'hFFFF_0000_FFFF_0000
) (
   input  logic              pclk,
   input  logic              presetn,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [31:0]       pwdata,
   output logic [31:0]       prdata,
   output logic              pready,
   output logic              pslverr,
   input  logic [NSRC-1:0]   irq_src,
   output logic              irq_req
);
   localparam int unsigned NWORD = NSRC / WORD_W;
   localparam int unsigned WA    = ADDR_W - 2;
   localparam int unsigned RAW   = $clog2(ROUTE_WORDS);
   localparam logic [WA-1:0] A_CTRL  = WA'(OFS_CTRL);
   localparam logic [WA-1:0] A_RT_LO = WA'(OFS_ROUTE);
   localparam logic [WA-1:0] A_RT_HI = WA'(OFS_ROUTE + ROUTE_WORDS - 1);

   if (NSRC != 64)                          $error("irqhub_apb: NSRC must be 64");
   if (ADDR_W < 7)                          $error("irqhub_apb: ADDR_W too small for map");
   if (IDX_W < $clog2(NSRC) || IDX_W > 8)   $error("irqhub_apb: IDX_W out of range");

   logic [WA-1:0]     word;
   logic              wr;
   logic              ctrl_on;
   logic [31:0]       en_w   [NWORD];
   logic [31:0]       flag_w [NWORD];
   logic [31:0]       pend_w [NWORD];
   logic [NSRC-1:0]   pend_all;
   logic              route_hit;
   logic [31:0]       route_rd;

   assign word    = paddr[ADDR_W-1:2];
   assign wr      = psel & penable & pwrite;
   assign pready  = 1'b1;
   assign pslverr = 1'b0;

   for (genvar w = 0; w < NWORD; w++) begin : g_word
      localparam logic [WA-1:0] A_EN   = WA'((w == 0) ? OFS_EN_LO : OFS_EN_HI);
      localparam logic [WA-1:0] A_FLAG = WA'(((w == 0) ? OFS_EN_LO : OFS_EN_HI) - FLAG_GAP);
      irqhub_word #(.W(32), .PULSE(PULSE_SRC[w*32 +: 32])) u_word (
         .clk     (pclk),
         .rst_n   (presetn),
         .src     (irq_src[w*32 +: 32]),
         .en_we   (wr && word == A_EN),
         .flag_we (wr && word == A_FLAG),
         .wdata   (pwdata),
         .en      (en_w[w]),
         .flag    (flag_w[w]),
         .pend    (pend_w[w])
      );
      assign pend_all[w*32 +: 32] = pend_w[w];
   end

   assign route_hit = (word >= A_RT_LO) && (word <= A_RT_HI);

   irqhub_route #(.SLOTS(ROUTE_WORDS * 4), .IDX_W(IDX_W)) u_route (
      .clk   (pclk),
      .rst_n (presetn),
      .we    (wr && route_hit),
      .wsel  (word[RAW-1:0]),
      .wdata (pwdata),
      .rsel  (word[RAW-1:0]),
      .rdata (route_rd)
   );

   always_ff @(posedge pclk or negedge presetn) begin
      if (!presetn)                  ctrl_on <= 1'b0;
      else if (wr && word == A_CTRL) ctrl_on <= pwdata[CTRL_ON_BIT];
   end

   always_ff @(posedge pclk or negedge presetn) begin
      if (!presetn) irq_req <= 1'b0;
      else          irq_req <= ctrl_on & (|pend_all);
   end

   always_comb begin
      prdata = '0;
      if (route_hit) prdata = route_rd;
      else if (word == A_CTRL) prdata[CTRL_ON_BIT] = ctrl_on;
      else if (word == WA'(OFS_EN_LO - FLAG_GAP)) prdata = flag_w[0];
      else if (word == WA'(OFS_EN_LO))            prdata = en_w[0];
      else if (word == WA'(OFS_PEND_LO))          prdata = pend_w[0];
      else if (word == WA'(OFS_EN_HI - FLAG_GAP)) prdata = flag_w[1];
      else if (word == WA'(OFS_EN_HI))            prdata = en_w[1];
      else if (word == WA'(OFS_PEND_HI))          prdata = pend_w[1];
   end

   // R8: request stays low while the master switch was off
   p_irq_gate_r8: assert property (@(posedge pclk) disable iff (!presetn)
      !$past(ctrl_on) |-> !irq_req);

   // R9: request follows the gated OR of pending one clock later
   p_irq_follow_r9: assert property (@(posedge pclk) disable iff (!presetn)
      $past(presetn) |-> (irq_req == $past(ctrl_on & (|pend_all))));

   // R3: a write to a pending word leaves the enables untouched
   p_pend_ro_r3: assert property (@(posedge pclk) disable iff (!presetn)
      (wr && (word == WA'(OFS_PEND_LO) || word == WA'(OFS_PEND_HI)))
      |=> ($stable(en_w[0]) && $stable(en_w[1])));
endmodule

// File: tb/sim_irqhub_apb.sv
module sim_irqhub_apb;
   localparam logic [63:0] PM = 64'hFFFF_0000_FFFF_0000;
   localparam logic [31:0] RMASK = 32'h3F3F_3F3F;

   logic        pclk = 1'b0;
   logic        presetn = 1'b0;
   logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [7:0]  paddr = '0;
   logic [31:0] pwdata = '0;
   logic [31:0] prdata;
   logic        pready, pslverr, irq_req;
   logic [63:0] lvl = '0, src_p = '0;
   logic [63:0] irq_src;

   logic [63:0] m_en = '0, m_flag = '0;
   logic        m_ctrl = 1'b0;
   logic [31:0] m_route [16];
   int          errors = 0, checks = 0;
   bit          done = 1'b0;

   always #4 pclk = ~pclk;
   assign irq_src = lvl | src_p;

   irqhub_apb #(.NSRC(64), .ADDR_W(8), .IDX_W(6), .PULSE_SRC(PM)) u0 (
      .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
      .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
      .pready(pready), .pslverr(pslverr), .irq_src(irq_src), .irq_req(irq_req));

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] exp_pend();
      return m_en & ((m_flag & PM) | (lvl & ~PM));
   endfunction

   function automatic logic [31:0] mdl_read(logic [7:0] a);
      logic [63:0] p = exp_pend();
      case (a[7:2])
         6'd0:  return {m_ctrl, 31'b0};
         6'd2:  return m_flag[31:0];
         6'd4:  return m_en[31:0];
         6'd5:  return p[31:0];
         6'd8:  return m_flag[63:32];
         6'd10: return m_en[63:32];
         6'd11: return p[63:32];
         default: return (a[7:6] == 2'b01) ? m_route[a[5:2]] : 32'h0;
      endcase
   endfunction

   function automatic void mdl_write(logic [7:0] a, logic [31:0] d);
      case (a[7:2])
         6'd0:  m_ctrl = d[31];
         6'd2:  m_flag[31:0]  = m_flag[31:0] & d;
         6'd4:  m_en[31:0]    = d;
         6'd8:  m_flag[63:32] = m_flag[63:32] & d;
         6'd10: m_en[63:32]   = d;
         default: if (a[7:6] == 2'b01) m_route[a[5:2]] = d & RMASK;
      endcase
   endfunction

   task automatic apb_wr(logic [7:0] a, logic [31:0] d);
      psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
      @(negedge pclk) penable = 1'b1;
      @(negedge pclk) begin psel = 1'b0; penable = 1'b0; pwrite = 1'b0; end
      mdl_write(a, d);
   endtask

   task automatic apb_rd(logic [7:0] a, output logic [31:0] d);
      psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
      @(negedge pclk) penable = 1'b1;
      #1 d = prdata;
      @(negedge pclk) begin psel = 1'b0; penable = 1'b0; end
   endtask

   task automatic rd_check(string req, logic [7:0] a);
      logic [31:0] d;
      apb_rd(a, d);
      check(req, d, mdl_read(a));
   endtask

   task automatic pulse(logic [63:0] bits);
      src_p = bits;
      @(negedge pclk) src_p = '0;
      m_flag = m_flag | (bits & PM);
   endtask

   task automatic irq_check(string req);
      @(negedge pclk);
      @(negedge pclk);
      check(req, 32'(irq_req), 32'(m_ctrl & (|exp_pend())));
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge pclk);
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_up();
   end

   initial begin
      logic [31:0] d;
      void'($urandom(32'd1234));
      for (int i = 0; i < 16; i++) m_route[i] = '0;
      repeat (3) @(negedge pclk);
      presetn = 1'b1;
      @(negedge pclk);

      // R1: reset state
      check("R1 pready", 32'(pready), 32'd1);
      check("R1 pslverr", 32'(pslverr), 32'd0);
      check("R1 irq_req", 32'(irq_req), 32'd0);
      foreach (m_route[i]) rd_check("R1 route", 8'(8'h40 + i*4));
      rd_check("R1 ctrl", 8'h00);
      rd_check("R1 en_lo", 8'h10);
      rd_check("R1 flag_hi", 8'h20);

      // R8: only bit 31 stored; request held low while off
      apb_wr(8'h10, 32'h0000_0001);
      lvl[0] = 1'b1;
      irq_check("R8 off gate");
      apb_wr(8'h00, 32'hFFFF_FFFF);
      rd_check("R8 ctrl bits", 8'h00);
      irq_check("R9 level on");

      // R4: level source follows input, flag stays 0
      rd_check("R4 pend level", 8'h14);
      rd_check("R4 flag level", 8'h08);
      lvl[0] = 1'b0;
      irq_check("R4 level drop");

      // R5: pulse flag sticks
      apb_wr(8'h10, 32'h0003_0000);
      pulse(64'h0000_0000_0003_0000);
      rd_check("R5 flag lo", 8'h08);
      rd_check("R5 pend lo", 8'h14);
      irq_check("R9 pulse irq");

      // R7: set on the same edge as a clear wins (bit 16 survives, bit 17 cleared)
      psel = 1'b1; pwrite = 1'b1; paddr = 8'h08; pwdata = 32'h0; penable = 1'b0;
      @(negedge pclk) begin penable = 1'b1; src_p = 64'h0000_0000_0001_0000; end
      @(negedge pclk) begin psel = 1'b0; penable = 1'b0; pwrite = 1'b0; src_p = '0; end
      m_flag[31:0] = 32'h0001_0000;
      rd_check("R7 set wins", 8'h08);

      // R6: writing 1 keeps, writing 0 clears, never sets
      pulse(64'h8000_0000_0000_0000);
      apb_wr(8'h20, 32'h7FFF_FFFF);
      rd_check("R6 clear hi", 8'h20);
      apb_wr(8'h08, 32'hFFFF_FFFF);
      rd_check("R6 keep lo", 8'h08);

      // R3: pending is read-only
      apb_wr(8'h14, 32'hFFFF_FFFF);
      rd_check("R3 en after pend wr", 8'h10);
      rd_check("R3 pend after wr", 8'h14);

      // R10: routing table, descending init pattern and masked upper bits
      apb_wr(8'h40, 32'h0001_0203);
      rd_check("R10 route init", 8'h40);
      apb_wr(8'h7C, 32'hFFFF_FFFF);
      rd_check("R10 route mask", 8'h7C);

      // R11: unmapped offsets
      apb_wr(8'h04, 32'hFFFF_FFFF);
      apb_wr(8'hC0, 32'hFFFF_FFFF);
      rd_check("R11 rd 04", 8'h04);
      rd_check("R11 rd 30", 8'h30);
      rd_check("R11 rd C0", 8'hC0);
      rd_check("R11 en intact", 8'h10);
      rd_check("R11 ctrl intact", 8'h00);

      // R2 plus random mix
      for (int it = 0; it < 400; it++) begin
         int op = int'($urandom_range(0, 6));
         case (op)
            0: apb_wr(8'h10, $urandom);
            1: apb_wr(8'h28, $urandom);
            2: lvl = {$urandom, $urandom} & ~PM;
            3: pulse({$urandom, $urandom} & {$urandom, $urandom});
            4: apb_wr($urandom_range(0, 1) ? 8'h08 : 8'h20, $urandom | $urandom);
            5: apb_wr(8'h00, {$urandom_range(0, 3) != 0, 31'h0});
            default: apb_wr(8'(8'h40 + 4 * $urandom_range(0, 15)), $urandom);
         endcase
         rd_check("R3 rnd pend lo", 8'h14);
         rd_check("R3 rnd pend hi", 8'h2C);
         rd_check("R2 rnd en hi", 8'h28);
         rd_check("R5 rnd flag", $urandom_range(0, 1) ? 8'h08 : 8'h20);
         irq_check("R9 rnd irq");
      end

      finish_up();
   end
endmodule